// File: doc/BRIEF.md
# 6502 to IDE select and strobe generator

This block sits between an 8-bit 6502-style host bus and the control side of an IDE device port. It watches the host's low address byte together with an active-low I/O-page select. When the page select is low, A3 is low and A7 is high, bits A4 to A6 pick one of three targets. Two of them are the IDE register-set chip selects and the third is a high-byte holding register that lives in an external data path. Whenever one of the three targets is hit, an active-high enable for an on-board peripheral is pulled low, which unmaps that peripheral from the shared I/O page.

Read and write strobes for the IDE device come from phi2 and the host R/W line. Both are qualified by a register-set hit, so no strobe reaches the device unless one of its register sets is addressed. The three low host address bits are captured on the first system clock edge that sees phi2 high after it was low. They are then held on the IDE register address lines for the rest of the phi2-high phase. The block also drives a combined register select, an activity indicator taken from the device's active-low activity line, and a device reset output that is low while the block is in reset and goes high afterwards.

Top module: `hostide_glue`

## Requirements
- R1: While io_sel_n is high, host_addr[3] is high or host_addr[7] is low, cs_set1_n, cs_set3_n and hib_sel_n are all high.
- R2: With the decoder enabled (io_sel_n low, host_addr[3] low, host_addr[7] high) and host_addr[4] high, {host_addr[6],host_addr[5]} = 01 drives hib_sel_n low, 10 drives cs_set1_n low and 11 drives cs_set3_n low. The value 00, or host_addr[4] low, selects nothing. At most one select is low at any time.
- R3: perip_en is low exactly when one of cs_set1_n, cs_set3_n or hib_sel_n is low, and high otherwise.
- R4: iow_n is low exactly when phi2 is high, rw is low (rw=1 means read) and cs_set1_n or cs_set3_n is low.
- R5: ior_n is low exactly when phi2 is high, rw is high and cs_set1_n or cs_set3_n is low.
- R6: ior_n and iow_n are never low together.
- R7: reg_sel_n is low exactly when cs_set1_n or cs_set3_n is low. A high-byte register access alone leaves it high.
- R8: ide_addr is 0 in reset. At a clk rising edge where phi2 is high and phi2 was low at the previous edge, it takes host_addr[2:0]. At every other edge it holds its value.
- R9: act_led is high exactly when dasp_n is low.
- R10: ide_rst_n is low while rst_n is low. It goes high at the first clk rising edge with rst_n high and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than phi2 |
| rst_n | input | 1 | Active-low asynchronous reset |
| phi2 | input | 1 | Host bus phase-2 clock, sampled as data |
| rw | input | 1 | Host read/write, 1 = read |
| io_sel_n | input | 1 | Active-low I/O-page select from the host's page decoder |
| host_addr | input | 8 | Host address bits A7..A0 |
| dasp_n | input | 1 | Active-low activity line from the IDE device |
| cs_set1_n | output | 1 | Active-low chip select for IDE register set 1 |
| cs_set3_n | output | 1 | Active-low chip select for IDE register set 3 |
| hib_sel_n | output | 1 | Active-low select for the high-byte holding register |
| perip_en | output | 1 | Enable for the on-board peripheral, low while the block is addressed |
| reg_sel_n | output | 1 | Active-low combined register-set select |
| ior_n | output | 1 | Active-low IDE read strobe |
| iow_n | output | 1 | Active-low IDE write strobe |
| ide_addr | output | 3 | IDE register address lines |
| act_led | output | 1 | Activity indicator, active high |
| ide_rst_n | output | 1 | Active-low IDE device reset |

## Verification
The bench builds the block with its default parameters: an 8-bit host address and three IDE address lines. At that width every host address can be swept against both page-select levels, both R/W levels and both phi2 phases. This reaches each decoder row, the strobe gating for every target and the unmap output on every combination. A second pass holds phi2 high while the address keeps changing, to show that the IDE address lines keep the value captured on the phi2 rise. Another step releases reset with phi2 already high, to cover capture on the first edge.

// File: rtl/hostide_pkg.sv
package hostide_pkg;

  // Decoded target of a host access within the I/O page
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_HIB  = 2'd1,
    TGT_SET1 = 2'd2,
    TGT_SET3 = 2'd3
  } tgt_e;

  // hi holds host address bits 7..3 (hi[0] = A3, hi[4] = A7)
  function automatic tgt_e decode_target(input logic page_n, input logic [4:0] hi);
    tgt_e t;
    t = TGT_NONE;
    if (!page_n && !hi[0] && hi[4] && hi[1]) begin
      case (hi[3:2])
        2'b01:   t = TGT_HIB;
        2'b10:   t = TGT_SET1;
        2'b11:   t = TGT_SET3;
        default: t = TGT_NONE;
      endcase
    end
    return t;
  endfunction

  // Strobe is active (low) only in phi2-high with a matching direction and a set hit
  function automatic logic strobe_n(input logic ph, input logic dir_ok, input logic hit);
    return ~(ph & dir_ok & hit);
  endfunction

endpackage

// File: rtl/hostide_decode.sv
module hostide_decode
  import hostide_pkg::*;
(
  input  logic       io_sel_n,
  input  logic [4:0] addr_hi,
  output logic       cs_set1_n,
  output logic       cs_set3_n,
  output logic       hib_sel_n,
  output logic       set_hit,
  output logic       any_hit
);
  tgt_e tgt;

  always_comb begin
    tgt       = decode_target(io_sel_n, addr_hi);
    cs_set1_n = (tgt != TGT_SET1);
    cs_set3_n = (tgt != TGT_SET3);
    hib_sel_n = (tgt != TGT_HIB);
    set_hit   = (tgt == TGT_SET1) || (tgt == TGT_SET3);
    any_hit   = (tgt != TGT_NONE);
  end
endmodule

// File: rtl/hostide_strobe.sv
module hostide_strobe
  import hostide_pkg::*;
(
  input  logic phi2,
  input  logic rw,
  input  logic set_hit,
  output logic ior_n,
  output logic iow_n
);
  always_comb begin
    ior_n = strobe_n(phi2, rw, set_hit);
    iow_n = strobe_n(phi2, ~rw, set_hit);
  end
endmodule

// File: rtl/hostide_addr_latch.sv
module hostide_addr_latch #(
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phi2,
  input  logic [AW-1:0] a_in,
  output logic [AW-1:0] a_out,
  output logic          phi2_rise,
  output logic          dev_rst_n
);
  logic phi2_q;

  assign phi2_rise = phi2 & ~phi2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi2_q    <= 1'b0;
      a_out     <= '0;
      dev_rst_n <= 1'b0;
    end else begin
      phi2_q    <= phi2;
      dev_rst_n <= 1'b1;
      if (phi2_rise) a_out <= a_in;
    end
  end
endmodule

// File: rtl/hostide_glue.sv
module hostide_glue #(
  parameter int unsigned HOST_AW = 8,
  parameter int unsigned IDE_AW  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phi2,
  input  logic               rw,
  input  logic               io_sel_n,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               dasp_n,
  output logic               cs_set1_n,
  output logic               cs_set3_n,
  output logic               hib_sel_n,
  output logic               perip_en,
  output logic               reg_sel_n,
  output logic               ior_n,
  output logic               iow_n,
  output logic [IDE_AW-1:0]  ide_addr,
  output logic               act_led,
  output logic               ide_rst_n
);
  localparam int unsigned DEC_LO = IDE_AW;
  localparam int unsigned DEC_HI = DEC_LO + 4;

  // Named internal events, visible to the bound checker
  logic set_hit;
  logic any_hit;
  logic phi2_rise;

  hostide_decode u_dec (
    .io_sel_n (io_sel_n),
    .addr_hi  (host_addr[DEC_HI:DEC_LO]),
    .cs_set1_n(cs_set1_n),
    .cs_set3_n(cs_set3_n),
    .hib_sel_n(hib_sel_n),
    .set_hit  (set_hit),
    .any_hit  (any_hit)
  );

  hostide_strobe u_stb (
    .phi2   (phi2),
    .rw     (rw),
    .set_hit(set_hit),
    .ior_n  (ior_n),
    .iow_n  (iow_n)
  );

  hostide_addr_latch #(.AW(IDE_AW)) u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .phi2     (phi2),
    .a_in     (host_addr[IDE_AW-1:0]),
    .a_out    (ide_addr),
    .phi2_rise(phi2_rise),
    .dev_rst_n(ide_rst_n)
  );

  assign perip_en  = ~any_hit;
  assign reg_sel_n = cs_set1_n & cs_set3_n;
  assign act_led   = ~dasp_n;

  if (HOST_AW > DEC_HI + 1) begin : g_spare
    logic spare_unused;
    assign spare_unused = ^host_addr[HOST_AW-1:DEC_HI+1];
  end
endmodule

// File: rtl/hostide_glue_chk.sv
module hostide_glue_chk #(
  parameter int unsigned HOST_AW = 8,
  parameter int unsigned IDE_AW  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               phi2,
  input logic               rw,
  input logic               io_sel_n,
  input logic [HOST_AW-1:0] host_addr,
  input logic               dasp_n,
  input logic               cs_set1_n,
  input logic               cs_set3_n,
  input logic               hib_sel_n,
  input logic               perip_en,
  input logic               reg_sel_n,
  input logic               ior_n,
  input logic               iow_n,
  input logic [IDE_AW-1:0]  ide_addr,
  input logic               act_led,
  input logic               ide_rst_n,
  input logic               phi2_rise
);
  p_idle_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel_n || host_addr[IDE_AW] || !host_addr[IDE_AW+4]) |-> (cs_set1_n && cs_set3_n && hib_sel_n));

  p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~cs_set1_n, ~cs_set3_n, ~hib_sel_n}));

  p_unmap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (perip_en == (cs_set1_n && cs_set3_n && hib_sel_n)));

  p_write_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !iow_n |-> (phi2 && !rw && !reg_sel_n));

  p_read_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ior_n |-> (phi2 && rw && !reg_sel_n));

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ior_n == 1'b0 && iow_n == 1'b0));

  p_reg_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hib_sel_n |-> reg_sel_n);

  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phi2_rise |=> (ide_addr == $past(host_addr[IDE_AW-1:0])));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2_rise |=> $stable(ide_addr));

  p_activity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_led != dasp_n));

  p_dev_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ide_rst_n);
endmodule

bind hostide_glue hostide_glue_chk #(.HOST_AW(HOST_AW), .IDE_AW(IDE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw(rw), .io_sel_n(io_sel_n),
  .host_addr(host_addr), .dasp_n(dasp_n), .cs_set1_n(cs_set1_n),
  .cs_set3_n(cs_set3_n), .hib_sel_n(hib_sel_n), .perip_en(perip_en),
  .reg_sel_n(reg_sel_n), .ior_n(ior_n), .iow_n(iow_n), .ide_addr(ide_addr),
  .act_led(act_led), .ide_rst_n(ide_rst_n), .phi2_rise(phi2_rise)
);

// File: tb/sim_hostide_glue.sv
`timescale 1ns/1ps
module sim_hostide_glue;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phi2 = 1'b0;
  logic       rw = 1'b1;
  logic       io_sel_n = 1'b1;
  logic [7:0] host_addr = 8'h00;
  logic       dasp_n = 1'b1;
  logic       cs_set1_n, cs_set3_n, hib_sel_n, perip_en, reg_sel_n, ior_n, iow_n;
  logic [2:0] ide_addr;
  logic       act_led, ide_rst_n;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  hostide_glue u0 (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw(rw), .io_sel_n(io_sel_n),
    .host_addr(host_addr), .dasp_n(dasp_n), .cs_set1_n(cs_set1_n),
    .cs_set3_n(cs_set3_n), .hib_sel_n(hib_sel_n), .perip_en(perip_en),
    .reg_sel_n(reg_sel_n), .ior_n(ior_n), .iow_n(iow_n), .ide_addr(ide_addr),
    .act_led(act_led), .ide_rst_n(ide_rst_n)
  );

  // Behavioural reference state, updated at each rising edge
  int ref_addr = 0;
  int ref_rst  = 0;
  bit ref_phi_prev = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_addr = 0; ref_rst = 0; ref_phi_prev = 0;
    end else begin
      if (phi2 && !ref_phi_prev) ref_addr = host_addr % 8;
      ref_phi_prev = phi2;
      ref_rst = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d addr=%02h io=%0b rw=%0b phi2=%0b",
               tag, act, exp, host_addr, io_sel_n, rw, phi2);
    end
  endtask

  task automatic compare_all();
    int target; // 0 none, 1 high byte, 2 set1, 3 set3
    bit set_sel;
    target = 0;
    if (io_sel_n == 0 && host_addr[3] == 0 && host_addr[7] == 1 && host_addr[4] == 1)
      target = host_addr[6] * 2 + host_addr[5];
    set_sel = (target >= 2);
    if (io_sel_n || host_addr[3] || !host_addr[7])
      chk("R1 selects idle", {cs_set1_n, cs_set3_n, hib_sel_n}, 7);
    chk("R2 set1 select", cs_set1_n, (target == 2) ? 0 : 1);
    chk("R2 set3 select", cs_set3_n, (target == 3) ? 0 : 1);
    chk("R2 high-byte select", hib_sel_n, (target == 1) ? 0 : 1);
    chk("R3 unmap", perip_en, (target != 0) ? 0 : 1);
    chk("R4 write strobe", iow_n, (phi2 && !rw && set_sel) ? 0 : 1);
    chk("R5 read strobe", ior_n, (phi2 && rw && set_sel) ? 0 : 1);
    chk("R6 no overlap", (!ior_n && !iow_n) ? 1 : 0, 0);
    chk("R7 combined select", reg_sel_n, set_sel ? 0 : 1);
    chk("R8 ide address", ide_addr, ref_addr);
    chk("R9 activity", act_led, dasp_n ? 0 : 1);
    chk("R10 device reset", ide_rst_n, ref_rst);
  endtask

  // Check the settled outputs, then drive the next inputs, on the falling edge
  task automatic step(input bit ph, input bit r, input bit io, input logic [7:0] a, input bit d);
    @(negedge clk);
    compare_all();
    phi2 = ph; rw = r; io_sel_n = io; host_addr = a; dasp_n = d;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // Reset state: R8 address 0, R10 device reset low
    repeat (3) step(1'b0, 1'b1, 1'b1, 8'h00, 1'b1);
    // Release reset with phi2 already high: capture on first edge (R8)
    @(negedge clk);
    phi2 = 1'b1; host_addr = 8'h05;
    rst_n = 1'b1;
    step(1'b1, 1'b1, 1'b1, 8'h05, 1'b1);
    step(1'b0, 1'b1, 1'b1, 8'h02, 1'b1);
    // Full sweep: every address, page select, direction and both phases
    for (int a = 0; a < 256; a++) begin
      for (int io = 0; io < 2; io++) begin
        for (int r = 0; r < 2; r++) begin
          step(1'b0, r[0], io[0], a[7:0], a[1] ^ r[0]);
          step(1'b1, r[0], io[0], a[7:0], a[0]);
        end
      end
    end
    // Hold: phi2 stays high while address moves; R8 keeps the captured value
    step(1'b0, 1'b0, 1'b0, 8'hE3, 1'b1);
    step(1'b1, 1'b0, 1'b0, 8'hE3, 1'b1);
    for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 1'b0, 8'hF0 + k[7:0], 1'b0);
    step(1'b0, 1'b1, 1'b0, 8'hD6, 1'b1);
    step(1'b1, 1'b1, 1'b0, 8'hD6, 1'b1);
    step(1'b1, 1'b1, 1'b1, 8'h00, 1'b1);
    step(1'b0, 1'b1, 1'b1, 8'h00, 1'b1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule